// File: doc/BRIEF.md
# DRAM Basic Access Sequencer

This block turns a single synchronous request into one complete, non-page-mode access to an asynchronous DRAM. A request carries an address, a read/write flag, two byte enables and write data. Once accepted, the block steps through four fixed clocks: a precharge clock, a row clock and two column clocks. During these clocks it drives the multiplexed address, the row strobe, separate upper-lane and lower-lane column strobes, the write enable, an output enable taken from the read strobe, a bus-start marker and the write data bus. On reads it captures the data bus.

The requester waits for `ready_o` and raises `req_i` for one clock. It can then watch for the one-clock `done_o` pulse. For a read, the captured word on `rdata_o` is valid from that pulse onward. Requests that arrive while an access is in flight are ignored.

Top module: `dram_seq`

## Requirements
- R1: An accepted request (`req_i` high while `ready_o` is high at a rising edge) runs exactly four clocks in the order precharge, row, column 1, column 2. `bs_no` is low only during the precharge clock. `ready_o` is high only when no access is in progress.
- R2: `ras_no` is high in idle and precharge. It is low from the row clock through column 2, and high again afterwards.
- R3: `ma_o` is zero in idle and precharge. In the row clock it carries `req_addr_i[ADDR_W-1:COL_W]`. In both column clocks it carries `req_addr_i[COL_W-1:0]`. Address bits above the active field width are zero.
- R4: `req_be_i[1]` selects `ucas_no` and `req_be_i[0]` selects `lcas_no`. A selected strobe is low only during column 2. With no byte enable set, the cycle still runs but neither strobe goes low.
- R5: On a read, `oe_no` is low in column 1 and column 2, and `we_no` stays high throughout.
- R6: On a write, `we_no` is low in column 1 and column 2, `oe_no` stays high, and `dq_oe_o` is high with `dq_o` equal to the write data in those two clocks. `dq_oe_o` is low at all other times.
- R7: On a read, `dq_i` is captured at the edge that ends column 2 and shown on `rdata_o`. A write leaves `rdata_o` unchanged.
- R8: `done_o` is high for exactly the one clock that follows column 2.
- R9: `req_i` held high during an access starts no new access and does not change the address of the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| req_addr_i | input | ADDR_W | Access address |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | 2 | Byte enables: bit 1 upper lane, bit 0 lower lane |
| req_wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Idle; a request is accepted |
| done_o | output | 1 | One-clock pulse after column 2 |
| rdata_o | output | DATA_W | Captured read data |
| ma_o | output | MA_W | Multiplexed row/column address |
| ras_no | output | 1 | Row strobe, active low |
| ucas_no | output | 1 | Upper-lane column strobe, active low |
| lcas_no | output | 1 | Lower-lane column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| oe_no | output | 1 | Output enable (read strobe), active low |
| bs_no | output | 1 | Bus-start marker, active low |
| dq_o | output | DATA_W | Write data to the DRAM |
| dq_oe_o | output | 1 | Drive enable for `dq_o` |
| dq_i | input | DATA_W | Read data from the DRAM |

## Verification
The hardest case to reach is a request that stays high for the whole of an access. Such a request must neither restart the sequence nor disturb the address that was latched. The bench holds `req_i` high with a different address from the accepting edge up to the done clock. It checks that the row and column carry the first address, that `bs_no` stays high and that no second access starts. A second hard case is the zero-byte-enable access, in which both column strobes must stay high while every other strobe runs as usual. It is paired with a write, so the bench can also confirm that the earlier read value survives on `rdata_o`.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TP   = 3'd1,
    ST_TR   = 3'd2,
    ST_TC1  = 3'd3,
    ST_TC2  = 3'd4
  } seq_st_e;
endpackage

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  output seq_st_e st_o,
  output logic    accept_o,
  output logic    done_o
);
  seq_st_e st_q, st_d;

  assign accept_o = (st_q == ST_IDLE) && req_i;

  always_comb begin
    case (st_q)
      ST_IDLE: st_d = accept_o ? ST_TP : ST_IDLE;
      ST_TP:   st_d = ST_TR;
      ST_TR:   st_d = ST_TC1;
      ST_TC1:  st_d = ST_TC2;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= (st_q == ST_TC2);
    end
  end

  assign st_o = st_q;

  AST_TP_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (st_q == ST_TP)); // R1
  AST_DONE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> !accept_o); // R9
endmodule

// File: rtl/dram_seq_addr_mux.sv
module dram_seq_addr_mux
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int COL_W  = 9,
  localparam int ROW_W = ADDR_W - COL_W,
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  seq_st_e           st_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MA_W-1:0]   ma_o
);
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  assign row = addr_i[ADDR_W-1:COL_W];
  assign col = addr_i[COL_W-1:0];

  always_comb begin
    case (st_i)
      ST_TR:         ma_o = MA_W'(row);
      ST_TC1, ST_TC2: ma_o = MA_W'(col);
      default:       ma_o = '0;
    endcase
  end
endmodule

// File: rtl/dram_seq_strobe.sv
module dram_seq_strobe
  import dram_seq_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_st_e          st_i,
  input  logic             wr_i,
  input  logic [LANES-1:0] be_i,
  output logic             ras_no,
  output logic [LANES-1:0] cas_no,
  output logic             we_no,
  output logic             oe_no,
  output logic             bs_no,
  output logic             dq_oe_o
);
  logic col_ph;

  assign col_ph  = (st_i == ST_TC1) || (st_i == ST_TC2);
  assign bs_no   = !(st_i == ST_TP);
  assign ras_no  = !((st_i == ST_TR) || col_ph);
  assign we_no   = !(col_ph && wr_i);
  assign oe_no   = !(col_ph && !wr_i);
  assign dq_oe_o = col_ph && wr_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_no[g] = !((st_i == ST_TC2) && be_i[g]);
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_no != '1) |-> !ras_no); // R4
  AST_OE_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_no && !we_no)); // R5
  AST_RAS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |=> !ras_no); // R2
  AST_BS_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bs_no |=> bs_no); // R1
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  localparam int ROW_W = ADDR_W - COL_W,
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wr_i,
  input  logic [1:0]        req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [MA_W-1:0]   ma_o,
  output logic              ras_no,
  output logic              ucas_no,
  output logic              lcas_no,
  output logic              we_no,
  output logic              oe_no,
  output logic              bs_no,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int LANES = 2;

  seq_st_e           st;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [LANES-1:0]  cas_n;

  dram_seq_fsm u_fsm (
    .clk_i, .rst_ni, .req_i,
    .st_o(st), .accept_o(accept), .done_o(done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      wr_q    <= req_wr_i;
      be_q    <= req_be_i;
      wdata_q <= req_wdata_i;
    end
  end

  // sample read data at the edge closing the second column clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (st == ST_TC2 && !wr_q) rdata_q <= dq_i;
  end

  dram_seq_addr_mux #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_mux (
    .st_i(st), .addr_i(addr_q), .ma_o(ma_o)
  );

  dram_seq_strobe #(.LANES(LANES)) u_strb (
    .clk_i, .rst_ni, .st_i(st), .wr_i(wr_q), .be_i(be_q),
    .ras_no(ras_no), .cas_no(cas_n), .we_no(we_no), .oe_no(oe_no),
    .bs_no(bs_no), .dq_oe_o(dq_oe_o)
  );

  assign ucas_no = cas_n[1];
  assign lcas_no = cas_n[0];
  assign ready_o = (st == ST_IDLE);
  assign rdata_o = rdata_q;
  assign dq_o    = dq_oe_o ? wdata_q : '0;

  AST_RDATA_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_TC2) |=> $stable(rdata_q)); // R7
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && st != ST_TP) |-> $stable(addr_q)); // R9
endmodule

// File: tb/dram_seq_test.sv
`timescale 1ns/1ps
module dram_seq_test;
  localparam int ADDR_W = 19;
  localparam int COL_W  = 9;
  localparam int MA_W   = 10;
  localparam int NV     = 6;

  localparam logic [ADDR_W-1:0] V_ADDR [NV] = '{19'h12345, 19'h7FFFF, 19'h00201, 19'h55AAA, 19'h3C0F0, 19'h0F00F};
  localparam logic              V_WR   [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [1:0]        V_BE   [NV] = '{2'b11, 2'b11, 2'b01, 2'b10, 2'b00, 2'b00};
  localparam logic [15:0]       V_WD   [NV] = '{16'h0000, 16'hBEEF, 16'h1234, 16'h0000, 16'h0000, 16'hCAFE};
  localparam logic [15:0]       V_RD   [NV] = '{16'hA5C3, 16'h1111, 16'h2222, 16'h0FF0, 16'h7E81, 16'h3333};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [1:0] be = '0;
  logic [15:0] wdata = '0, dq_in = '0;
  logic ready, done, ras_n, ucas_n, lcas_n, we_n, oe_n, bs_n, dq_oe;
  logic [15:0] rdata, dq_out;
  logic [MA_W-1:0] ma;
  int total = 0, bad = 0;
  logic [15:0] exp_rdata = '0;

  always #4 clk = ~clk;

  dram_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(addr), .req_wr_i(wr),
    .req_be_i(be), .req_wdata_i(wdata), .ready_o(ready), .done_o(done),
    .rdata_o(rdata), .ma_o(ma), .ras_no(ras_n), .ucas_no(ucas_n), .lcas_no(lcas_n),
    .we_no(we_n), .oe_no(oe_n), .bs_no(bs_n), .dq_o(dq_out), .dq_oe_o(dq_oe), .dq_i(dq_in)
  );

  task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // phase: 0=Tp 1=Tr 2=Tc1 3=Tc2 4=idle
  task automatic chk_phase(input int ph, input logic [ADDR_W-1:0] a, input logic w,
                           input logic [1:0] b, input logic [15:0] wd);
    logic col = (ph == 2) || (ph == 3);
    logic [MA_W-1:0] ema;
    logic [7:0] obs, exp;
    ema = (ph == 1) ? MA_W'(a[ADDR_W-1:COL_W]) : col ? MA_W'(a[COL_W-1:0]) : '0;
    obs = {ready, bs_n, ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe};
    exp = {ph == 4, ph != 0, !(ph >= 1 && ph <= 3), !(ph == 3 && b[1]), !(ph == 3 && b[0]),
           !(col && w), !(col && !w), col && w};
    chk(obs[7:6] == exp[7:6], "R1 ready/bs", 32'(obs), 32'(exp));
    chk(obs[5] == exp[5], "R2 ras", 32'(obs), 32'(exp));
    chk(ma == ema, "R3 ma", 32'(ma), 32'(ema));
    chk(obs[4:3] == exp[4:3], "R4 cas", 32'(obs), 32'(exp));
    if (w) chk(obs[2:0] == exp[2:0] && (!col || dq_out == wd), "R6 we/oe/dq",
               {obs, dq_out}, {exp, wd});
    else   chk(obs[2:0] == exp[2:0], "R5 we/oe", 32'(obs), 32'(exp));
  endtask

  task automatic run_access(input logic [ADDR_W-1:0] a, input logic w, input logic [1:0] b,
                            input logic [15:0] wd, input logic [15:0] rd);
    @(negedge clk);
    req = 1'b1; addr = a; wr = w; be = b; wdata = wd; dq_in = rd;
    @(negedge clk);
    req = 1'b0;
    for (int p = 0; p < 4; p++) begin
      chk_phase(p, a, w, b, wd);
      chk(!done, "R8 no early done", 32'(done), 0);
      @(negedge clk);
    end
    if (!w) exp_rdata = rd;
    chk_phase(4, a, w, b, wd);
    chk(done, "R8 done pulse", 32'(done), 1);
    chk(rdata == exp_rdata, "R7 rdata", 32'(rdata), 32'(exp_rdata));
    @(negedge clk);
    chk(!done, "R8 done one clock", 32'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk({ready, done, ras_n, ucas_n, lcas_n, we_n, oe_n, bs_n, dq_oe} == 9'b101111110,
        "R1 reset outputs", 32'({ready, done, ras_n, ucas_n, lcas_n, we_n, oe_n, bs_n, dq_oe}), 32'h17E);
    chk(ma == '0 && rdata == '0, "R3 reset ma/rdata", {ma, rdata}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bs_n && ready, "R1 idle without req", 32'({bs_n, ready}), 3);

    for (int i = 0; i < NV; i++)
      run_access(V_ADDR[i], V_WR[i], V_BE[i], V_WD[i], V_RD[i]);

    // request held high through whole access: no restart, first address kept (R9)
    @(negedge clk);
    req = 1'b1; addr = 19'h2AB55; wr = 1'b0; be = 2'b11; dq_in = 16'h4242;
    @(negedge clk);
    addr = 19'h1FFFF;
    chk_phase(0, 19'h2AB55, 1'b0, 2'b11, 16'h0);
    for (int p = 1; p < 4; p++) begin
      @(negedge clk);
      chk_phase(p, 19'h2AB55, 1'b0, 2'b11, 16'h0);
      chk(bs_n && !ready, "R9 busy ignores req", 32'({bs_n, ready}), 2);
    end
    @(negedge clk);
    req = 1'b0;
    chk(done && rdata == 16'h4242, "R9 first access completes", {15'd0, done, rdata}, 32'h14242);
    @(negedge clk);
    chk(bs_n && ready && ras_n, "R9 no second access", 32'({bs_n, ready, ras_n}), 7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule